// File: doc/BRIEF.md
# Closed-Loop Memory Rank Thermal Throttle

This block watches the temperature of a set of memory ranks and turns the readings into a limit on column (CAS) command bandwidth for the memory scheduler. Readings arrive one at a time on a valid/data port, each tagged with a rank index. The block groups them into sampling rounds whose length in clocks comes from a runtime register. At the close of each round it picks the hottest rank and compares that rank's temperature against a warm limit and a hot limit. The result is one of three throttle levels.

If a rank sends no reading during a round, one of two things happens. In plain mode the rank keeps its last recorded value. In hybrid mode the rank takes an externally supplied estimate instead. Software may rewrite both limits at any time. A new limit is used only at the next round close, so the level never changes part way through a round.

The scheduler side works in fixed windows of 256 clocks. At the start of each window a CAS budget is loaded from the current level. Each granted CAS request uses one unit of that budget. Once the budget reaches zero, further requests are denied until the next window begins.

Top module: `rank_thermal_throttle`

## Requirements
- R1: After reset the hottest-rank index is 0, the hottest temperature is 0, the throttle level is 0, and the CAS budget is 256, so a CAS request is granted.
- R2: The hottest-rank index, hottest temperature and throttle level change only at the clock edge that closes a round. A round lasts `interval_cfg` clocks, counted from reset or from the previous close, and a value of 0 behaves like 1.
- R3: At a round close the block reports the rank with the greatest effective temperature. When several ranks share the maximum, the lowest index wins.
- R4: With `hybrid_en` low, a rank that sent no reading during the round keeps the value it was last given. That value is 0 after reset.
- R5: With `hybrid_en` high, a rank that sent no reading during the round takes the value of `est_temp` at the closing edge, and that value is recorded for it.
- R6: The throttle level is 2 when the hottest temperature is greater than or equal to `hot_limit`. Otherwise it is 1 when that temperature is greater than or equal to `warm_limit`. Otherwise it is 0. Comparisons are unsigned.
- R7: A change to `warm_limit` or `hot_limit` has no effect on the throttle level until the next round close, where the values present at that edge are used.
- R8: Every 256 clocks from reset, the CAS budget reloads to 256, 128 or 32 for levels 0, 1 and 2 respectively.
- R9: `cas_grant` is high exactly when `cas_req` is high and the budget is non-zero. Each grant lowers the budget by one. Without requests the budget holds.
- R10: A level change that happens inside a window leaves that window's budget untouched. The new level applies from the next reload.
- R11: When one rank sends several readings within a round, the last one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_cfg | input | 16 | Round length in clocks (0 acts as 1) |
| warm_limit | input | 8 | Temperature at or above which the level becomes 1 |
| hot_limit | input | 8 | Temperature at or above which the level becomes 2 |
| hybrid_en | input | 1 | Fill missing readings with `est_temp` |
| est_temp | input | 8 | Estimated temperature for ranks without a reading |
| smp_valid | input | 1 | A rank reading is present this cycle |
| smp_rank | input | 2 | Rank index of the reading |
| smp_temp | input | 8 | Temperature of the reading |
| cas_req | input | 1 | Scheduler wants to issue a CAS command |
| cas_grant | output | 1 | CAS command allowed this cycle |
| cas_budget | output | 9 | CAS slots left in the current window |
| hot_rank | output | 2 | Index of the hottest rank at the last round close |
| hot_temp | output | 8 | Temperature of that rank |
| throttle_level | output | 2 | 0 full, 1 half, 2 one-eighth bandwidth |

## Verification
The bench targets several corner cases. It forces two ranks to share the maximum; a design that kept the later one would report index 2 instead of 0. It sends two readings to one rank in a single round; a design that latched the first would report the wrong hottest rank. It leaves ranks silent in both modes; a design that zeroed them, or ignored the estimate, would report a wrong maximum. It also rewrites limits mid-round and moves the level mid-window. It expects the old level and the old budget to persist, and it counts grants over whole windows at each level, so a budget that was off by one, or a deny that leaked through, would show up in the counts.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

    typedef enum logic [1:0] {
        LVL_FULL   = 2'd0,
        LVL_HALF   = 2'd1,
        LVL_EIGHTH = 2'd2
    } thr_level_e;

endpackage

// File: rtl/rtt_sample_store.sv
module rtt_sample_store #(
    parameter int NUM_RANKS = 4,
    parameter int TEMP_W    = 8,
    parameter int RANK_W    = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               smp_valid,
    input  logic [RANK_W-1:0]                  smp_rank,
    input  logic [TEMP_W-1:0]                  smp_temp,
    input  logic                               hybrid_en,
    input  logic [TEMP_W-1:0]                  est_temp,
    input  logic                               round_end,
    output logic [NUM_RANKS-1:0][TEMP_W-1:0]   eff_temp
);

    typedef struct packed {
        logic [NUM_RANKS-1:0][TEMP_W-1:0] temp;
        logic [NUM_RANKS-1:0]             seen;
    } store_t;

    store_t st_q, st_d;
    logic [NUM_RANKS-1:0][TEMP_W-1:0] cur_temp;
    logic [NUM_RANKS-1:0]             hit;

    // Per rank: the newest reading overrides the stored one; a rank not
    // heard from this round is filled from the estimate or its last value.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_RANKS; i++) begin
            hit[i]      = smp_valid && (smp_rank == RANK_W'(i));
            cur_temp[i] = hit[i] ? smp_temp : st_q.temp[i];
            if (st_q.seen[i] || hit[i]) begin
                eff_temp[i] = cur_temp[i];
            end else if (hybrid_en) begin
                eff_temp[i] = est_temp;
            end else begin
                eff_temp[i] = st_q.temp[i];
            end
            if (round_end) begin
                st_d.temp[i] = eff_temp[i];
                st_d.seen[i] = 1'b0;
            end else begin
                st_d.temp[i] = cur_temp[i];
                st_d.seen[i] = st_q.seen[i] | hit[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank_chk
        assert_hold_unsampled_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!round_end && !(smp_valid && smp_rank == RANK_W'(g))) |=> $stable(st_q.temp[g]));
    end

endmodule

// File: rtl/rtt_max_select.sv
module rtt_max_select #(
    parameter int NUM_RANKS = 4,
    parameter int TEMP_W    = 8,
    parameter int RANK_W    = 2
) (
    input  logic [NUM_RANKS-1:0][TEMP_W-1:0] temps,
    output logic [RANK_W-1:0]                max_rank,
    output logic [TEMP_W-1:0]                max_temp
);

    // Strict compare keeps the earliest index on ties.
    always_comb begin
        max_rank = '0;
        max_temp = temps[0];
        for (int i = 1; i < NUM_RANKS; i++) begin
            if (temps[i] > max_temp) begin
                max_rank = RANK_W'(i);
                max_temp = temps[i];
            end
        end
    end

endmodule

// File: rtl/rtt_cas_budget.sv
module rtt_cas_budget #(
    parameter int WINDOW = 256,
    parameter int BUD_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  rtt_pkg::thr_level_e     level,
    input  logic                    cas_req,
    output logic                    cas_grant,
    output logic [BUD_W-1:0]        budget
);

    import rtt_pkg::*;

    localparam int               WIN_W    = $clog2(WINDOW);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [BUD_W-1:0] Q_FULL   = BUD_W'(WINDOW);
    localparam logic [BUD_W-1:0] Q_HALF   = BUD_W'(WINDOW / 2);
    localparam logic [BUD_W-1:0] Q_EIGHTH = BUD_W'(WINDOW / 8);

    typedef struct packed {
        logic [WIN_W-1:0] win_cnt;
        logic [BUD_W-1:0] budget;
    } bud_t;

    bud_t             b_q, b_d;
    logic             wrap;
    logic [BUD_W-1:0] quota;

    always_comb begin
        b_d = b_q;
        unique case (level)
            LVL_HALF:   quota = Q_HALF;
            LVL_EIGHTH: quota = Q_EIGHTH;
            default:    quota = Q_FULL;
        endcase
        cas_grant = cas_req && (b_q.budget != '0);
        wrap      = (b_q.win_cnt == WIN_LAST);
        if (wrap) begin
            b_d.win_cnt = '0;
            b_d.budget  = quota;
        end else begin
            b_d.win_cnt = b_q.win_cnt + WIN_W'(1);
            b_d.budget  = b_q.budget - BUD_W'(cas_grant);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q.win_cnt <= '0;
            b_q.budget  <= Q_FULL;
        end else begin
            b_q <= b_d;
        end
    end

    assign budget = b_q.budget;

    assert_budget_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.win_cnt != WIN_LAST) |=> (b_q.budget == $past(b_q.budget) - BUD_W'($past(cas_grant))));

    assert_budget_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_q.win_cnt != WIN_LAST) && !cas_req) |=> $stable(b_q.budget));

    assert_reload_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.win_cnt == WIN_LAST) |=>
            (b_q.budget == Q_FULL || b_q.budget == Q_HALF || b_q.budget == Q_EIGHTH));

    assert_budget_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        b_q.budget <= Q_FULL);

endmodule

// File: rtl/rank_thermal_throttle.sv
module rank_thermal_throttle #(
    parameter int  NUM_RANKS  = 4,
    parameter int  TEMP_W     = 8,
    parameter int  INTERVAL_W = 16,
    parameter int  WINDOW     = 256,
    localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int BUD_W      = $clog2(WINDOW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INTERVAL_W-1:0] interval_cfg,
    input  logic [TEMP_W-1:0]     warm_limit,
    input  logic [TEMP_W-1:0]     hot_limit,
    input  logic                  hybrid_en,
    input  logic [TEMP_W-1:0]     est_temp,
    input  logic                  smp_valid,
    input  logic [RANK_W-1:0]     smp_rank,
    input  logic [TEMP_W-1:0]     smp_temp,
    input  logic                  cas_req,
    output logic                  cas_grant,
    output logic [BUD_W-1:0]      cas_budget,
    output logic [RANK_W-1:0]     hot_rank,
    output logic [TEMP_W-1:0]     hot_temp,
    output logic [1:0]            throttle_level
);

    import rtt_pkg::*;

    typedef struct packed {
        logic [INTERVAL_W-1:0] rnd_cnt;
        logic [RANK_W-1:0]     hot_rank;
        logic [TEMP_W-1:0]     hot_temp;
        thr_level_e            level;
    } ctl_t;

    ctl_t                             c_q, c_d;
    logic                             round_end;
    logic [INTERVAL_W:0]              cnt_plus1;
    logic [NUM_RANKS-1:0][TEMP_W-1:0] eff_temp;
    logic [RANK_W-1:0]                max_rank;
    logic [TEMP_W-1:0]                max_temp;

    rtt_sample_store #(
        .NUM_RANKS (NUM_RANKS),
        .TEMP_W    (TEMP_W),
        .RANK_W    (RANK_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_rank  (smp_rank),
        .smp_temp  (smp_temp),
        .hybrid_en (hybrid_en),
        .est_temp  (est_temp),
        .round_end (round_end),
        .eff_temp  (eff_temp)
    );

    rtt_max_select #(
        .NUM_RANKS (NUM_RANKS),
        .TEMP_W    (TEMP_W),
        .RANK_W    (RANK_W)
    ) u_max (
        .temps    (eff_temp),
        .max_rank (max_rank),
        .max_temp (max_temp)
    );

    rtt_cas_budget #(
        .WINDOW (WINDOW),
        .BUD_W  (BUD_W)
    ) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (c_q.level),
        .cas_req   (cas_req),
        .cas_grant (cas_grant),
        .budget    (cas_budget)
    );

    // Round timer, hottest-rank capture and level decision. Limits are only
    // looked at on the closing edge, so a rewrite waits for the next close.
    always_comb begin
        c_d       = c_q;
        cnt_plus1 = {1'b0, c_q.rnd_cnt} + (INTERVAL_W + 1)'(1);
        round_end = (cnt_plus1 >= {1'b0, interval_cfg});
        if (round_end) begin
            c_d.rnd_cnt  = '0;
            c_d.hot_rank = max_rank;
            c_d.hot_temp = max_temp;
            if (max_temp >= hot_limit) begin
                c_d.level = LVL_EIGHTH;
            end else if (max_temp >= warm_limit) begin
                c_d.level = LVL_HALF;
            end else begin
                c_d.level = LVL_FULL;
            end
        end else begin
            c_d.rnd_cnt = cnt_plus1[INTERVAL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.rnd_cnt  <= '0;
            c_q.hot_rank <= '0;
            c_q.hot_temp <= '0;
            c_q.level    <= LVL_FULL;
        end else begin
            c_q <= c_d;
        end
    end

    assign hot_rank       = c_q.hot_rank;
    assign hot_temp       = c_q.hot_temp;
    assign throttle_level = c_q.level;

    assert_hold_between_rounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !round_end |=> ($stable(c_q.hot_temp) && $stable(c_q.hot_rank)));

    assert_level_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !round_end |=> $stable(c_q.level));

    assert_hot_vs_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        round_end |=> ((c_q.level == LVL_EIGHTH) == (c_q.hot_temp >= $past(hot_limit))));

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_max_chk
        assert_max_dominates_R3: assert property (@(posedge clk) disable iff (!rst_n)
            round_end |=> (c_q.hot_temp >= $past(eff_temp[g])));
    end

endmodule

// File: tb/rank_thermal_throttle_bench.sv
module rank_thermal_throttle_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [15:0] interval_cfg;
    logic [7:0] warm_limit, hot_limit, est_temp, smp_temp, hot_temp;
    logic       hybrid_en, smp_valid, cas_req, cas_grant;
    logic [1:0] smp_rank, hot_rank, throttle_level;
    logic [8:0] cas_budget;

    always #4 clk = ~clk;

    rank_thermal_throttle u_rank_thermal_throttle (
        .clk            (clk),
        .rst_n          (rst_n),
        .interval_cfg   (interval_cfg),
        .warm_limit     (warm_limit),
        .hot_limit      (hot_limit),
        .hybrid_en      (hybrid_en),
        .est_temp       (est_temp),
        .smp_valid      (smp_valid),
        .smp_rank       (smp_rank),
        .smp_temp       (smp_temp),
        .cas_req        (cas_req),
        .cas_grant      (cas_grant),
        .cas_budget     (cas_budget),
        .hot_rank       (hot_rank),
        .hot_temp       (hot_temp),
        .throttle_level (throttle_level)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ival = 40;
    bit done = 0;

    typedef struct {
        int    rank;
        int    temp;
        int    lvl;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   mtemp[4];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Monitor: at each round close, pop the expected result and compare.
    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst_n && cyc != 0 && (cyc % ival) == 0 && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(int'(hot_rank) == e.rank, {e.req, " hot_rank"}, int'(hot_rank), e.rank);
            chk(int'(hot_temp) == e.temp, {e.req, " hot_temp"}, int'(hot_temp), e.temp);
            chk(int'(throttle_level) == e.lvl, {e.req, " level"}, int'(throttle_level), e.lvl);
        end
    end

    task automatic wait_round;
        do @(negedge clk); while ((cyc % ival) != 0);
    endtask

    task automatic wait_window;
        do @(negedge clk); while ((cyc % 256) != 0);
    endtask

    task automatic drive_sample(input int r, input int t);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_rank  = 2'(r);
        smp_temp  = 8'(t);
    endtask

    task automatic end_samples;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Driver side of the scoreboard: model the round and queue the result.
    task automatic expect_round(input bit [3:0] present, input int v0, input int v1,
                                input int v2, input int v3, input string req);
        int   tv[4];
        int   eff;
        exp_t e;
        tv = '{v0, v1, v2, v3};
        e.rank = 0;
        e.temp = -1;
        for (int i = 0; i < 4; i++) begin
            eff = present[i] ? tv[i] : (hybrid_en ? int'(est_temp) : mtemp[i]);
            mtemp[i] = eff;
            if (eff > e.temp) begin
                e.temp = eff;
                e.rank = i;
            end
        end
        e.lvl = (e.temp >= int'(hot_limit)) ? 2 : (e.temp >= int'(warm_limit)) ? 1 : 0;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic full_round(input bit [3:0] present, input int v0, input int v1,
                              input int v2, input int v3, input string req);
        int tv[4];
        tv = '{v0, v1, v2, v3};
        wait_round;
        for (int i = 0; i < 4; i++) if (present[i]) drive_sample(i, tv[i]);
        end_samples;
        expect_round(present, v0, v1, v2, v3, req);
    endtask

    task automatic count_window(input int exp_grants, input string req);
        int g;
        g = 0;
        cas_req = 1'b1;
        #1;
        for (int k = 0; k < 256; k++) begin
            if (cas_grant) g++;
            if (k == 250 && exp_grants < 250) begin
                chk(cas_grant == 1'b0, {req, " deny at zero"}, int'(cas_grant), 0);
                chk(cas_budget == 9'd0, {req, " empty budget"}, int'(cas_budget), 0);
            end
            @(negedge clk);
        end
        cas_req = 1'b0;
        chk(g == exp_grants, {req, " grants per window"}, g, exp_grants);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        rst_n = 1'b0; interval_cfg = 16'd40; warm_limit = 8'd60; hot_limit = 8'd80;
        hybrid_en = 1'b0; est_temp = 8'd0; smp_valid = 1'b0; smp_rank = 2'd0;
        smp_temp = 8'd0; cas_req = 1'b0;
        for (int i = 0; i < 4; i++) mtemp[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(hot_rank == 2'd0, "R1 hot_rank", int'(hot_rank), 0);
        chk(hot_temp == 8'd0, "R1 hot_temp", int'(hot_temp), 0);
        chk(throttle_level == 2'd0, "R1 level", int'(throttle_level), 0);
        chk(cas_budget == 9'd256, "R1 budget", int'(cas_budget), 256);
        cas_req = 1'b1;
        #1;
        chk(cas_grant == 1'b1, "R1 grant", int'(cas_grant), 1);
        cas_req = 1'b0;

        full_round(4'b1111, 30, 55, 42, 10, "R3 distinct");
        full_round(4'b1111, 70, 20, 70, 5, "R3 tie R6 warm");
        full_round(4'b1000, 0, 0, 0, 90, "R4 missing kept R6 hot");

        // R11: two readings for rank 2, the later one counts
        wait_round;
        drive_sample(2, 99);
        drive_sample(2, 50);
        end_samples;
        expect_round(4'b0100, 0, 0, 50, 0, "R11 last reading");

        // R7: limit rewrite waits for the round close
        wait_round;
        warm_limit = 8'd5;
        hot_limit  = 8'd200;
        @(negedge clk);
        chk(throttle_level == 2'd2, "R7 level held after rewrite", int'(throttle_level), 2);
        for (int i = 0; i < 4; i++) drive_sample(i, 10);
        end_samples;
        expect_round(4'b1111, 10, 10, 10, 10, "R7 new limits at close");
        do @(negedge clk); while ((cyc % ival) != ival - 1);
        chk(hot_temp == 8'd90, "R2 held before close", int'(hot_temp), 90);
        chk(throttle_level == 2'd2, "R7 level before close", int'(throttle_level), 2);

        // R5 hybrid fill
        wait_round;
        warm_limit = 8'd60; hot_limit = 8'd80; hybrid_en = 1'b1; est_temp = 8'd77;
        drive_sample(1, 40);
        end_samples;
        expect_round(4'b0010, 0, 40, 0, 0, "R5 estimate fill");
        wait_round;
        est_temp = 8'd85;
        @(negedge clk);
        expect_round(4'b0000, 0, 0, 0, 0, "R5 all estimated");
        wait_round;
        hybrid_en = 1'b0;
        @(negedge clk);
        expect_round(4'b0000, 0, 0, 0, 0, "R4 estimate kept");
        wait_round;

        // R8/R9 at level 2
        wait_window;
        chk(cas_budget == 9'd32, "R8 eighth reload", int'(cas_budget), 32);
        count_window(32, "R9 eighth");
        chk(cas_budget == 9'd32, "R8 reload after window", int'(cas_budget), 32);
        repeat (20) @(negedge clk);
        chk(cas_budget == 9'd32, "R9 idle hold", int'(cas_budget), 32);

        // R10: level drops mid-window, budget unchanged
        full_round(4'b1111, 65, 10, 10, 10, "R10 level to half");
        wait_round;
        chk(cas_budget == 9'd32, "R10 budget kept mid-window", int'(cas_budget), 32);
        wait_window;
        chk(cas_budget == 9'd128, "R8 half reload", int'(cas_budget), 128);
        count_window(128, "R9 half");

        full_round(4'b1111, 10, 10, 10, 10, "R6 cool");
        wait_window;
        chk(cas_budget == 9'd256, "R8 full reload", int'(cas_budget), 256);
        count_window(256, "R8 full");

        // R2 with a different interval after a fresh reset
        @(negedge clk);
        rst_n = 1'b0;
        interval_cfg = 16'd12;
        ival = 12;
        for (int i = 0; i < 4; i++) mtemp[i] = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) drive_sample(i, i + 1);
        end_samples;
        expect_round(4'b1111, 1, 2, 3, 4, "R2 short interval");
        do @(negedge clk); while (cyc != 11);
        chk(hot_temp == 8'd0, "R2 held until 12th edge", int'(hot_temp), 0);
        wait_round;

        // R2: interval 0 closes a round every clock
        interval_cfg = 16'd0;
        ival = 1;
        smp_valid = 1'b1; smp_rank = 2'd1; smp_temp = 8'd200;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(hot_temp == 8'd200, "R2 zero interval temp", int'(hot_temp), 200);
        chk(hot_rank == 2'd1, "R2 zero interval rank", int'(hot_rank), 1);
        chk(throttle_level == 2'd2, "R6 zero interval level", int'(throttle_level), 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule